// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block rearranges the contents of a 256-bit vector register under the control of an 8-bit immediate. It handles two operations, chosen by the opcode field of a 32-bit instruction word. The doubleword permute fills each of the four 64-bit output lanes with any lane of the source register. The quadword permute treats the old destination and the source as one 512-bit operand. It fills each 128-bit half of the output with any of the four 128-bit pieces of that operand.

An execution pipeline places one request per cycle on the inputs, marked with a valid strobe. The result comes back on a registered output one clock later, together with its own valid flag. An opcode that matches neither operation is not executed. The old destination passes through unchanged and an illegal flag is raised alongside it.

Top module: `vperm_unit`

## Requirements
- R1: With the doubleword operation, output bits [64k+63:64k] (k = 0..3) equal source bits [64j+63:64j], where j is the immediate field imm[2k+1:2k].
- R2: With the quadword operation, the 512-bit operand is {dst_old, src}. Piece 0 is src[127:0], piece 1 is src[255:128], piece 2 is dst_old[127:0] and piece 3 is dst_old[255:128].
- R3: With the quadword operation, result[127:0] is the piece numbered by imm[1:0], and result[255:128] is the piece numbered by imm[5:4].
- R4: With the quadword operation, imm[3:2] and imm[7:6] have no effect on the result.
- R5: The operation is decoded from instr[31:18] alone. The value 14'h1dfa selects the doubleword operation and 14'h1dfb selects the quadword operation. instr[17:0] are ignored.
- R6: Any other value of instr[31:18] gives result equal to dst_old with illegal at 1. Both legal operations give illegal at 0.
- R7: A request accepted at a rising edge with in_valid high appears on result, illegal and out_valid after that edge. A cycle with in_valid low drives out_valid low at the next edge and leaves result unchanged.
- R8: While rst is high at a rising edge, the next state is out_valid 0, illegal 0 and result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word; bits [31:18] hold the opcode |
| imm | input | 8 | Immediate lane selectors |
| dst_old | input | 256 | Current destination register value |
| src | input | 256 | Source register value |
| out_valid | output | 1 | Result present this cycle |
| result | output | 256 | Permuted vector, or dst_old for an illegal opcode |
| illegal | output | 1 | The request had an unknown opcode |

## Verification
The assertions assume that instr, imm, dst_old and src carry known values in every cycle where in_valid is high. They also assume that rst is held high for at least one rising edge before requests begin. The bench meets both conditions. It drives every operand from full-width random words, gives every request a fresh random value in the ignored instruction bits, and holds reset for several cycles first. It runs all 256 immediates through both operations and a set of neighbouring and unrelated opcodes. Idle gaps between requests exercise the hold behaviour of the output register.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int LANE_W  = 64;
    localparam int N_LANES = 4;
    localparam int VEC_W   = LANE_W * N_LANES;
    localparam int PIECE_W = 2 * LANE_W;
    localparam int N_PIECE = 2 * VEC_W / PIECE_W;
    localparam int N_HALF  = VEC_W / PIECE_W;
    localparam int IMM_W   = 8;
    localparam int SEL_W   = $clog2(N_LANES);
    localparam int INSTR_W = 32;
    localparam int OPC_LSB = 18;
    localparam int OPC_W   = INSTR_W - OPC_LSB;

    localparam logic [OPC_W-1:0] OPC_DWORD = 14'h1dfa;
    localparam logic [OPC_W-1:0] OPC_QWORD = 14'h1dfb;

    typedef enum logic [1:0] {
        OP_DWORD = 2'd0,
        OP_QWORD = 2'd1,
        OP_BAD   = 2'd2
    } vperm_op_e;

    typedef struct packed {
        logic             valid;
        logic             bad;
        logic [VEC_W-1:0] data;
    } vperm_out_t;

    function automatic logic [OPC_W-1:0] opc_field(input logic [INSTR_W-1:0] w);
        return w[INSTR_W-1:OPC_LSB];
    endfunction

    function automatic vperm_op_e op_of(input logic [OPC_W-1:0] opc);
        vperm_op_e o;
        if (opc == OPC_DWORD)      o = OP_DWORD;
        else if (opc == OPC_QWORD) o = OP_QWORD;
        else                       o = OP_BAD;
        return o;
    endfunction

    function automatic logic [LANE_W-1:0] lane_of(input logic [VEC_W-1:0] v,
                                                  input logic [SEL_W-1:0] idx);
        logic [LANE_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_LANES; i++)
            if (idx == SEL_W'(i)) r = v[i*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic [PIECE_W-1:0] piece_of(input logic [2*VEC_W-1:0] v,
                                                    input logic [1:0] idx);
        logic [PIECE_W-1:0] r;
        r = '0;
        for (int i = 0; i < N_PIECE; i++)
            if (idx == 2'(i)) r = v[i*PIECE_W +: PIECE_W];
        return r;
    endfunction

endpackage

// File: rtl/vperm_decode.sv
module vperm_decode
    import vperm_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output vperm_op_e          op
);
    logic [OPC_W-1:0] opc;
    logic             unused_low_bits;

    assign opc             = opc_field(instr);
    assign unused_low_bits = ^instr[OPC_LSB-1:0];
    assign op              = op_of(opc);
endmodule

// File: rtl/vperm_dword_sel.sv
module vperm_dword_sel
    import vperm_pkg::*;
(
    input  logic [VEC_W-1:0] src,
    input  logic [IMM_W-1:0] imm,
    output logic [VEC_W-1:0] res
);
    logic [LANE_W-1:0] lanes [N_LANES];

    always_comb begin
        for (int i = 0; i < N_LANES; i++)
            lanes[i] = src[i*LANE_W +: LANE_W];
    end

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = imm[k*SEL_W +: SEL_W];
        assign res[k*LANE_W +: LANE_W] = lanes[sel];
    end
endmodule

// File: rtl/vperm_qword_sel.sv
module vperm_qword_sel
    import vperm_pkg::*;
(
    input  logic [VEC_W-1:0] dst_old,
    input  logic [VEC_W-1:0] src,
    input  logic [1:0]       sel_lo,
    input  logic [1:0]       sel_hi,
    output logic [VEC_W-1:0] res
);
    logic [PIECE_W-1:0] pieces [N_PIECE];
    logic [1:0]         sels   [N_HALF];
    logic [2*VEC_W-1:0] joined;

    assign joined  = {dst_old, src};
    assign sels[0] = sel_lo;
    assign sels[1] = sel_hi;

    always_comb begin
        for (int i = 0; i < N_PIECE; i++)
            pieces[i] = joined[i*PIECE_W +: PIECE_W];
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign res[h*PIECE_W +: PIECE_W] = pieces[sels[h]];
    end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [IMM_W-1:0]   imm,
    input  logic [VEC_W-1:0]   dst_old,
    input  logic [VEC_W-1:0]   src,
    output logic               out_valid,
    output logic [VEC_W-1:0]   result,
    output logic               illegal
);
    vperm_op_e        op;
    logic [VEC_W-1:0] dw_res;
    logic [VEC_W-1:0] qw_res;
    vperm_out_t       nxt;
    vperm_out_t       q;

    vperm_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    vperm_dword_sel u_dw (
        .src (src),
        .imm (imm),
        .res (dw_res)
    );

    vperm_qword_sel u_qw (
        .dst_old (dst_old),
        .src     (src),
        .sel_lo  (imm[1:0]),
        .sel_hi  (imm[5:4]),
        .res     (qw_res)
    );

    always_comb begin
        nxt.valid = in_valid;
        nxt.bad   = 1'b0;
        unique case (op)
            OP_DWORD: nxt.data = dw_res;
            OP_QWORD: nxt.data = qw_res;
            default: begin
                nxt.data = dst_old;
                nxt.bad  = in_valid;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= nxt.valid;
            q.bad   <= nxt.bad;
            if (in_valid) q.data <= nxt.data;
        end
    end

    assign out_valid = q.valid;
    assign illegal   = q.bad;
    assign result    = q.data;
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk
    import vperm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [IMM_W-1:0]   imm,
    input logic [VEC_W-1:0]   dst_old,
    input logic [VEC_W-1:0]   src,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result,
    input logic               illegal
);
    logic is_dw, is_qw;
    assign is_dw = (instr[INSTR_W-1:OPC_LSB] == OPC_DWORD);
    assign is_qw = (instr[INSTR_W-1:OPC_LSB] == OPC_QWORD);

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal && result == '0));

    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    a_r6_bad_passes_dst: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_dw && !is_qw) |=> (illegal && result == $past(dst_old)));

    a_r6_legal_no_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (is_dw || is_qw)) |=> !illegal);

    a_r1_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_dw) |=> result[LANE_W-1:0] == $past(lane_of(src, imm[1:0])));

    a_r1_lane3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_dw) |=> result[VEC_W-1 -: LANE_W] == $past(lane_of(src, imm[7:6])));

    a_r3_low_half: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_qw) |=> result[PIECE_W-1:0] == $past(piece_of({dst_old, src}, imm[1:0])));

    a_r3_high_half: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_qw) |=> result[VEC_W-1:PIECE_W] == $past(piece_of({dst_old, src}, imm[5:4])));
endmodule

bind vperm_unit vperm_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .imm       (imm),
    .dst_old   (dst_old),
    .src       (src),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/vperm_unit_tb_top.sv
module vperm_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic [7:0]   imm;
    logic [255:0] dst_old;
    logic [255:0] src;
    logic         out_valid;
    logic [255:0] result;
    logic         illegal;

    typedef struct {
        logic [255:0] res;
        logic         ill;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           n_run  = 0;
    int           n_fail = 0;
    logic [255:0] last_res = '0;
    bit           done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vperm_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .imm(imm),
        .dst_old(dst_old), .src(src), .out_valid(out_valid), .result(result),
        .illegal(illegal)
    );

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    // Behavioural model from R1..R6
    function automatic logic [255:0] model(input logic [13:0] opc, input logic [7:0] iv,
                                           input logic [255:0] d, input logic [255:0] s,
                                           output logic ill);
        logic [255:0] r;
        logic [511:0] cat;
        int idx;
        ill = 1'b0;
        r   = '0;
        cat = {d, s};
        if (opc == 14'h1dfa) begin
            for (int k = 0; k < 4; k++) begin
                idx = int'(iv[2*k +: 2]);
                for (int b = 0; b < 64; b++) r[64*k + b] = s[64*idx + b];
            end
        end else if (opc == 14'h1dfb) begin
            for (int h = 0; h < 2; h++) begin
                idx = int'(iv[4*h +: 2]);
                for (int b = 0; b < 128; b++) r[128*h + b] = cat[128*idx + b];
            end
        end else begin
            r   = d;
            ill = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [13:0] opc, input logic [7:0] iv,
                        input logic [255:0] d, input logic [255:0] s, input string tag);
        logic [31:0] low;
        exp_t e;
        low = $urandom();
        @(negedge clk);
        in_valid = 1'b1;
        instr    = {opc, low[17:0]};
        imm      = iv;
        dst_old  = d;
        src      = s;
        e.res    = model(opc, iv, d, s, e.ill);
        e.tag    = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr    = $urandom();
            imm      = 8'($urandom());
        end
    endtask

    // Monitor: pops the scoreboard as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", {255'd0, out_valid}, 256'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, e.tag, result, e.res);
                    check(illegal == e.ill, {e.tag, " R6 flag"},
                          {255'd0, illegal}, {255'd0, e.ill});
                    last_res = e.res;
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [255:0] d, s;
        rst = 1'b1; in_valid = 1'b0; instr = '0; imm = '0; dst_old = '0; src = '0;
        repeat (4) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 out_valid", {255'd0, out_valid}, 256'd0);
        check(illegal == 1'b0, "R8 illegal", {255'd0, illegal}, 256'd0);
        check(result == '0, "R8 result", result, 256'd0);
        rst = 1'b0;

        // R1 R5: every immediate, doubleword operation
        for (int i = 0; i < 256; i++) begin
            send(14'h1dfa, 8'(i), rnd256(), rnd256(), "R1 R5 dword");
            if (i % 37 == 36) idle(2);
        end
        // R2 R3 R4 R5: every immediate, quadword operation
        for (int i = 0; i < 256; i++) begin
            send(14'h1dfb, 8'(i), rnd256(), rnd256(), "R2 R3 R4 R5 qword");
            if (i % 41 == 40) idle(1);
        end
        // R4: same operands, ignored bits flipped
        d = rnd256(); s = rnd256();
        send(14'h1dfb, 8'h21, d, s, "R4 ignored bits clear");
        send(14'h1dfb, 8'hED, d, s, "R4 ignored bits set");
        // R6: unknown opcodes
        send(14'h1df9, 8'h1B, rnd256(), rnd256(), "R6 opcode 1df9");
        send(14'h1dfc, 8'hE4, rnd256(), rnd256(), "R6 opcode 1dfc");
        send(14'h0000, 8'h55, rnd256(), rnd256(), "R6 opcode 0000");
        send(14'h3fff, 8'hAA, rnd256(), rnd256(), "R6 opcode 3fff");
        send(14'h0dfa, 8'h39, rnd256(), rnd256(), "R6 opcode 0dfa");
        send(14'h1ce3, 8'h4B, rnd256(), rnd256(), "R6 opcode 1ce3");
        send(14'h1dfa, 8'h93, rnd256(), rnd256(), "R1 after illegal");

        idle(3);
        // R7: idle cycles keep output and drop valid
        check(out_valid == 1'b0, "R7 idle valid", {255'd0, out_valid}, 256'd0);
        check(result == last_res, "R7 idle hold", result, last_res);
        check(sb.size() == 0, "R7 scoreboard drained", 256'(sb.size()), 256'd0);

        // R8: reset after traffic
        send(14'h1dfb, 8'h32, rnd256(), rnd256(), "R3 before reset");
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 late out_valid", {255'd0, out_valid}, 256'd0);
        check(result == '0, "R8 late result", result, 256'd0);
        check(illegal == 1'b0, "R8 late illegal", {255'd0, illegal}, 256'd0);
        rst = 1'b0;
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule